// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single reservation of one hart for load-reserved / store-conditional pairs. A load-reserved records a reserved footprint: a 64-bit aligned granule address and an 8-bit byte mask. The monitor then watches every store that reaches shared memory. Each observed store carries the ID of the hart that issued it. Only a store from a different hart that writes at least one reserved byte destroys the reservation. Stores from the owning hart may land in between without harm.

When the store-conditional arrives, the monitor returns a result one cycle later. On success it issues the conditional's memory write in that same cycle, so the commit and the write are one indivisible step. The write goes to memory once and is never offered for forwarding. The hart can also force a failure in two ways. An early failure is used before the address is known. A late failure can be used at any point before the write would issue. In both cases the store is discarded. Every store-conditional clears the reservation, whether it succeeds or fails.

Top module: `rsv_monitor`

## Requirements
- R1: After reset there is no reservation, and `scDone`, `scResult` and `memWrValid` are all 0.
- R2: A store-conditional that follows a load-reserved succeeds when all four of these hold: its granule address equals the reserved one, its byte mask is non-zero, the mask lies inside the reserved mask, and nothing broke the reservation. In the cycle after the request, `scDone`=1, `scResult`=0 and `memWrValid`=1, with `memWrAddr`/`memWrMask`/`memWrData` equal to the request.
- R3: A store-conditional with no live reservation fails: `scResult`=1 and `memWrValid`=0.
- R4: An observed store whose hart ID differs from `OWN_HART` kills the reservation when it hits the same granule and shares at least one mask bit with the reserved mask. A later store-conditional then fails. Such a store in the same cycle as the store-conditional also makes it fail.
- R5: An observed store carrying `OWN_HART` never breaks the reservation. A store from another hart also leaves it intact when it goes to another granule or to disjoint bytes of the same granule.
- R6: A store-conditional fails, with no write, in any of three cases: its granule address differs from the reserved one, its mask has a bit outside the reserved mask, or its mask is all zero.
- R7: A store-conditional with `scEarlyFail` or `scLateFail` set fails, and no write is issued.
- R8: Any store-conditional clears the reservation. A second store-conditional with no load-reserved in between fails.
- R9: A load-reserved that coincides with a killing store from another hart still leaves a live reservation, because that store is ordered before the reserved read. A load-reserved that coincides with a store-conditional is dropped. The store-conditional is judged against the old reservation, and the reservation ends cleared.
- R10: A new load-reserved replaces any older reservation.
- R11: `scDone` is a one-cycle pulse in the cycle after each store-conditional. Its encoding: `scResult`=1 means failure and 0 means success, and `scResult` is 0 whenever `scDone` is 0. `memWrValid` is high for exactly that one cycle, and only on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrValid | input | 1 | Load-reserved request |
| lrAddr | input | ADDR_W | Granule address to reserve |
| lrMask | input | DATA_W/8 | Bytes to reserve within the granule |
| storeValid | input | 1 | A store reached shared memory this cycle |
| storeHart | input | HART_W | Hart that issued the observed store |
| storeAddr | input | ADDR_W | Granule address of the observed store |
| storeMask | input | DATA_W/8 | Bytes written by the observed store |
| scValid | input | 1 | Store-conditional request |
| scAddr | input | ADDR_W | Store-conditional granule address |
| scMask | input | DATA_W/8 | Store-conditional byte mask |
| scData | input | DATA_W | Store-conditional data |
| scEarlyFail | input | 1 | Force failure before the address is known |
| scLateFail | input | 1 | Force failure before the write issues |
| scDone | output | 1 | Result valid pulse |
| scResult | output | 1 | 1 = failed, 0 = succeeded |
| memWrValid | output | 1 | Atomic commit write to memory |
| memWrAddr | output | ADDR_W | Write granule address |
| memWrMask | output | DATA_W/8 | Write byte mask |
| memWrData | output | DATA_W | Write data |

## Verification
The bench first aims at byte-level overlap. It sends stores from another hart to disjoint bytes and to a neighbouring granule. A monitor that compared only addresses would wrongly fail those conditionals. A monitor that ignored the mask intersection would wrongly pass a single shared byte. It then sends stores from the owning hart, which a hart-blind design would treat as a kill. It also covers several same-cycle collisions: a load-reserved with a killing store, a conditional with a killing store, and a load-reserved with a conditional. Wrong priority in any of these would flip the result or leave a stale reservation. Repeated conditionals, an empty mask and forced failures show whether the reservation is cleared and whether a discarded store can still reach memory.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic setRes;   // capture a new reservation
    logic clrRes;   // drop the current reservation
    logic scPass;   // conditional succeeds: commit and write
    logic scFail;   // conditional fails: report, discard store
  } rsvStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic resValid;      // a reservation is live
    logic storeOverlap;  // observed store touches a reserved byte
    logic scFits;        // conditional lies inside the reservation
  } rsvStatus_t;

endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int HART_W   = 3,
  parameter int OWN_HART = 2
) (
  input  logic              lrValid,
  input  logic              scValid,
  input  logic              scEarlyFail,
  input  logic              scLateFail,
  input  logic              storeValid,
  input  logic [HART_W-1:0] storeHart,
  input  rsvStatus_t        status,
  output rsvStrobe_t        strobe
);

  localparam logic [HART_W-1:0] OwnId = HART_W'(OWN_HART);

  logic foreignKill;
  logic forcedFail;
  logic scOk;

  // Only a store from another hart that overlaps a reserved byte breaks it.
  assign foreignKill = storeValid && (storeHart != OwnId) && status.storeOverlap;
  assign forcedFail  = scEarlyFail || scLateFail;

  // A same-cycle foreign kill is ordered before the conditional.
  assign scOk = scValid && !forcedFail && status.resValid && status.scFits && !foreignKill;

  always_comb begin
    strobe        = '0;
    strobe.scPass = scOk;
    strobe.scFail = scValid && !scOk;
    // A conditional in the same cycle wins over a load-reserved.
    strobe.setRes = lrValid && !scValid;
    strobe.clrRes = scValid || foreignKill;
  end

endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rsvStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   lrAddr,
  input  logic [DATA_W/8-1:0] lrMask,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic [DATA_W/8-1:0] storeMask,
  input  logic [ADDR_W-1:0]   scAddr,
  input  logic [DATA_W/8-1:0] scMask,
  input  logic [DATA_W-1:0]   scData,
  output rsvStatus_t          status,
  output logic                scDone,
  output logic                scResult,
  output logic                memWrValid,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W/8-1:0] memWrMask,
  output logic [DATA_W-1:0]   memWrData
);

  localparam int MASK_W = DATA_W / 8;

  logic              resValid;
  logic [ADDR_W-1:0] resAddr;
  logic [MASK_W-1:0] resMask;

  logic [MASK_W-1:0] laneHit;   // store byte that is also reserved
  logic [MASK_W-1:0] laneOut;   // conditional byte outside reservation

  for (genvar b = 0; b < MASK_W; b++) begin : g_lane
    assign laneHit[b] = storeMask[b] & resMask[b];
    assign laneOut[b] = scMask[b] & ~resMask[b];
  end

  always_comb begin
    status              = '0;
    status.resValid     = resValid;
    status.storeOverlap = resValid && (storeAddr == resAddr) && (|laneHit);
    status.scFits       = (scAddr == resAddr) && (|scMask) && !(|laneOut);
  end

  // Reservation register: a new reservation has priority over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resAddr  <= '0;
      resMask  <= '0;
    end else if (strobe.setRes) begin
      resValid <= 1'b1;
      resAddr  <= lrAddr;
      resMask  <= lrMask;
    end else if (strobe.clrRes) begin
      resValid <= 1'b0;
    end
  end

  // Result and commit write in the same registered step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scDone     <= 1'b0;
      scResult   <= 1'b0;
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrMask  <= '0;
      memWrData  <= '0;
    end else begin
      scDone     <= strobe.scPass || strobe.scFail;
      scResult   <= strobe.scFail;
      memWrValid <= strobe.scPass;
      if (strobe.scPass) begin
        memWrAddr <= scAddr;
        memWrMask <= scMask;
        memWrData <= scData;
      end
    end
  end

  AST_WR_INSIDE_RES: assert property (@(posedge clk) disable iff (!rst_n)
    memWrValid |-> ($past(resValid) && (($past(scMask) & ~$past(resMask)) == '0))); // R6
  AST_SC_CLEARS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.scPass || strobe.scFail) |=> !resValid); // R8
  AST_LR_ARMS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setRes |=> resValid); // R9

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int HART_W   = 3,
  parameter int OWN_HART = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrValid,
  input  logic [ADDR_W-1:0]   lrAddr,
  input  logic [DATA_W/8-1:0] lrMask,
  input  logic                storeValid,
  input  logic [HART_W-1:0]   storeHart,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic [DATA_W/8-1:0] storeMask,
  input  logic                scValid,
  input  logic [ADDR_W-1:0]   scAddr,
  input  logic [DATA_W/8-1:0] scMask,
  input  logic [DATA_W-1:0]   scData,
  input  logic                scEarlyFail,
  input  logic                scLateFail,
  output logic                scDone,
  output logic                scResult,
  output logic                memWrValid,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W/8-1:0] memWrMask,
  output logic [DATA_W-1:0]   memWrData
);

  rsvStrobe_t strobe;
  rsvStatus_t status;

  rsv_ctrl #(.HART_W(HART_W), .OWN_HART(OWN_HART)) u_ctrl (
    .lrValid     (lrValid),
    .scValid     (scValid),
    .scEarlyFail (scEarlyFail),
    .scLateFail  (scLateFail),
    .storeValid  (storeValid),
    .storeHart   (storeHart),
    .status      (status),
    .strobe      (strobe)
  );

  rsv_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .lrAddr     (lrAddr),
    .lrMask     (lrMask),
    .storeAddr  (storeAddr),
    .storeMask  (storeMask),
    .scAddr     (scAddr),
    .scMask     (scMask),
    .scData     (scData),
    .status     (status),
    .scDone     (scDone),
    .scResult   (scResult),
    .memWrValid (memWrValid),
    .memWrAddr  (memWrAddr),
    .memWrMask  (memWrMask),
    .memWrData  (memWrData)
  );

  AST_DONE_FOLLOWS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    scValid |=> scDone); // R11
  AST_IDLE_RESULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !scDone |-> (!scResult && !memWrValid)); // R11
  AST_WRITE_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    memWrValid |-> (scDone && !scResult)); // R2
  AST_FORCED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (scValid && (scEarlyFail || scLateFail)) |=> (scResult && !memWrValid)); // R7
  AST_FOREIGN_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (scValid && storeValid && (storeHart != HART_W'(OWN_HART)) && (storeAddr == scAddr)
     && ((storeMask & scMask) != '0)) |=> scResult); // R4

endmodule

// File: tb/rsv_monitor_bench.sv
`timescale 1ns/1ps
module rsv_monitor_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int MASK_W = DATA_W / 8;
  localparam int HART_W = 3;
  localparam int OWN    = 2;
  localparam int OTHER  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              lrValid = 0, storeValid = 0, scValid = 0, scEarlyFail = 0, scLateFail = 0;
  logic [ADDR_W-1:0] lrAddr = 0, storeAddr = 0, scAddr = 0;
  logic [MASK_W-1:0] lrMask = 0, storeMask = 0, scMask = 0;
  logic [HART_W-1:0] storeHart = 0;
  logic [DATA_W-1:0] scData = 0;
  logic              scDone, scResult, memWrValid;
  logic [ADDR_W-1:0] memWrAddr;
  logic [MASK_W-1:0] memWrMask;
  logic [DATA_W-1:0] memWrData;

  rsv_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HART_W(HART_W), .OWN_HART(OWN)) u_rsv_monitor (
    .clk(clk), .rst_n(rst_n),
    .lrValid(lrValid), .lrAddr(lrAddr), .lrMask(lrMask),
    .storeValid(storeValid), .storeHart(storeHart), .storeAddr(storeAddr), .storeMask(storeMask),
    .scValid(scValid), .scAddr(scAddr), .scMask(scMask), .scData(scData),
    .scEarlyFail(scEarlyFail), .scLateFail(scLateFail),
    .scDone(scDone), .scResult(scResult), .memWrValid(memWrValid),
    .memWrAddr(memWrAddr), .memWrMask(memWrMask), .memWrData(memWrData)
  );

  int checks = 0;
  int fails  = 0;

  // stKind: 0 none, 1 own hart, 2 other hart
  typedef struct packed {
    logic [15:0] lrA; logic [7:0] lrM;
    logic [1:0]  stK; logic [15:0] stA; logic [7:0] stM;
    logic [15:0] scA; logic [7:0] scM;
    logic early; logic late; logic expFail;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 8'hFF, 2'd0, 16'h0000, 8'h00, 16'h0010, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{16'h0010, 8'h0F, 2'd0, 16'h0000, 8'h00, 16'h0010, 8'h03, 1'b0, 1'b0, 1'b0},
    '{16'h0010, 8'h0F, 2'd0, 16'h0000, 8'h00, 16'h0010, 8'h1F, 1'b0, 1'b0, 1'b1},
    '{16'h0010, 8'hFF, 2'd0, 16'h0000, 8'h00, 16'h0011, 8'hFF, 1'b0, 1'b0, 1'b1},
    '{16'h0020, 8'hF0, 2'd1, 16'h0020, 8'hF0, 16'h0020, 8'hF0, 1'b0, 1'b0, 1'b0},
    '{16'h0020, 8'hF0, 2'd2, 16'h0020, 8'h10, 16'h0020, 8'hF0, 1'b0, 1'b0, 1'b1},
    '{16'h0020, 8'hF0, 2'd2, 16'h0020, 8'h0F, 16'h0020, 8'hF0, 1'b0, 1'b0, 1'b0},
    '{16'h0020, 8'hF0, 2'd2, 16'h0021, 8'hF0, 16'h0020, 8'hF0, 1'b0, 1'b0, 1'b0},
    '{16'h0030, 8'hFF, 2'd0, 16'h0000, 8'h00, 16'h0030, 8'hFF, 1'b1, 1'b0, 1'b1},
    '{16'h0030, 8'hFF, 2'd0, 16'h0000, 8'h00, 16'h0030, 8'hFF, 1'b0, 1'b1, 1'b1},
    '{16'h0030, 8'hFF, 2'd0, 16'h0000, 8'h00, 16'h0030, 8'h00, 1'b0, 1'b0, 1'b1},
    '{16'h0040, 8'h80, 2'd2, 16'h0040, 8'h81, 16'h0040, 8'h80, 1'b0, 1'b0, 1'b1}
  };

  function automatic string vecReq(int i);
    case (i)
      0, 1:     return "R2";
      2, 3, 10: return "R6";
      4, 6, 7:  return "R5";
      5, 11:    return "R4";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Advance one edge, then clear all request inputs.
  task automatic tick();
    @(posedge clk); #1;
    lrValid = 0; storeValid = 0; scValid = 0; scEarlyFail = 0; scLateFail = 0;
  endtask

  task automatic setLr(logic [15:0] a, logic [7:0] m);
    lrValid = 1; lrAddr = a; lrMask = m;
  endtask

  task automatic setSt(int h, logic [15:0] a, logic [7:0] m);
    storeValid = 1; storeHart = HART_W'(h); storeAddr = a; storeMask = m;
  endtask

  task automatic setSc(logic [15:0] a, logic [7:0] m, logic [63:0] d);
    scValid = 1; scAddr = a; scMask = m; scData = d;
  endtask

  // Checks outcome sampled one cycle after the conditional.
  task automatic chkSc(string req, logic expFail);
    chk(req, "scDone", 64'(scDone), 64'd1);
    chk(req, "scResult", 64'(scResult), 64'(expFail));
    chk(req, "memWrValid", 64'(memWrValid), 64'(!expFail));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "scDone", 64'(scDone), 64'd0);
    chk("R1", "scResult", 64'(scResult), 64'd0);
    chk("R1", "memWrValid", 64'(memWrValid), 64'd0);
    rst_n = 1;
    tick();

    // R3 conditional right after reset, no reservation
    setSc(16'h0010, 8'hFF, 64'h1);
    tick();
    chkSc("R3", 1'b1);

    // Table of scenarios: load-reserved, optional store, conditional
    for (int i = 0; i < NV; i++) begin
      logic [63:0] d;
      d = 64'hA5A5_0000_0000_0000 | 64'(i);
      setLr(VECS[i].lrA, VECS[i].lrM);
      tick();
      if (VECS[i].stK != 2'd0) begin
        setSt(VECS[i].stK == 2'd1 ? OWN : OTHER, VECS[i].stA, VECS[i].stM);
        tick();
      end
      setSc(VECS[i].scA, VECS[i].scM, d);
      scEarlyFail = VECS[i].early;
      scLateFail  = VECS[i].late;
      tick();
      chkSc(vecReq(i), VECS[i].expFail);
      if (!VECS[i].expFail) begin
        chk(vecReq(i), "memWrAddr", 64'(memWrAddr), 64'(VECS[i].scA));
        chk(vecReq(i), "memWrMask", 64'(memWrMask), 64'(VECS[i].scM));
        chk(vecReq(i), "memWrData", memWrData, d);
      end
      tick();
    end

    // R8 and R11: pass, then the pulse drops, then a second conditional fails
    setLr(16'h0050, 8'hFF); tick();
    setSc(16'h0050, 8'hFF, 64'h55); tick();
    chkSc("R8", 1'b0);
    tick();
    chk("R11", "scDone after pulse", 64'(scDone), 64'd0);
    chk("R11", "memWrValid after pulse", 64'(memWrValid), 64'd0);
    chk("R11", "scResult idle", 64'(scResult), 64'd0);
    setSc(16'h0050, 8'hFF, 64'h56); tick();
    chkSc("R8", 1'b1);
    tick();

    // R4 foreign store in the same cycle as the conditional
    setLr(16'h0060, 8'h0F); tick();
    setSt(OTHER, 16'h0060, 8'h01);
    setSc(16'h0060, 8'h0F, 64'h60); tick();
    chkSc("R4", 1'b1);
    tick();

    // R5 own-hart store in the same cycle as the conditional
    setLr(16'h0061, 8'h0F); tick();
    setSt(OWN, 16'h0061, 8'h0F);
    setSc(16'h0061, 8'h0F, 64'h61); tick();
    chkSc("R5", 1'b0);
    tick();

    // R9 load-reserved coinciding with a killing foreign store survives
    setLr(16'h0070, 8'hFF);
    setSt(OTHER, 16'h0070, 8'hFF); tick();
    setSc(16'h0070, 8'hFF, 64'h70); tick();
    chkSc("R9", 1'b0);
    tick();

    // R9 load-reserved coinciding with a conditional is dropped
    setLr(16'h0080, 8'hFF); tick();
    setLr(16'h0090, 8'hFF);
    setSc(16'h0090, 8'hFF, 64'h90); tick();
    chkSc("R9", 1'b1);
    setSc(16'h0090, 8'hFF, 64'h91); tick();
    chkSc("R9", 1'b1);
    tick();

    // R10 a newer load-reserved replaces the older one
    setLr(16'h00A0, 8'hFF); tick();
    setLr(16'h00B0, 8'hFF); tick();
    setSc(16'h00A0, 8'hFF, 64'hA0); tick();
    chkSc("R10", 1'b1);
    setLr(16'h00A0, 8'hFF); tick();
    setLr(16'h00B0, 8'h3C); tick();
    setSc(16'h00B0, 8'h3C, 64'hB0); tick();
    chkSc("R10", 1'b0);
    chk("R10", "memWrAddr", 64'(memWrAddr), 64'h00B0);
    tick();

    summary();
    $finish;
  end

endmodule